// File: doc/BRIEF.md
# Write-Masked GPIO Register Bank

This block is a 32-pin general-purpose I/O bank with a word-addressed register interface. Each logical 32-bit register is stored as two 16-bit halves at neighbouring word addresses. Pins 0 to 15 sit at the register's base offset and pins 16 to 31 sit at base+4. A write never overwrites a half as a whole. The upper 16 bits of the written word act as a per-bit enable for the lower 16 bits. This lets software set, clear or change any group of pins in one bus write, without first reading the register. It also means two agents that own different pins cannot undo each other's updates.

The output-data register drives the pin output vector, and the direction register drives the output-enable vector. Six further configuration registers (interrupt enable, interrupt mask, trigger type, polarity, dual-edge and debounce enable) are stored and read back in the same split, write-masked form. The pin input vector passes through a two-flop synchroniser and can be read at the external-port offsets. A constant identification word can be read at its own offset. Reads are combinational from the address. Any offset that is unmapped or not word-aligned reads as zero and ignores writes.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset, pin_out and pin_oe are all zero, and every configuration register reads zero.
- R2: A write to a register half changes bit n of that half only when bit n+16 of the write data is 1. Bits whose enable is 0 keep their value, even when the matching data bit differs.
- R3: Pins 15..0 of each logical register sit at its base offset and pins 31..16 at base+4. A write to one half leaves the other half unchanged.
- R4: pin_out mirrors the output-data register at offset 0x00, and pin_oe mirrors the direction register at offset 0x08. A direction bit of 1 makes the pin an output.
- R5: The configuration registers at offsets 0x10, 0x18, 0x20, 0x28, 0x30 and 0x38 (each with a second half at +4) accept masked writes. Reading one returns its 16 stored bits in [15:0], with [31:16] zero.
- R6: Offset 0x70 returns pins 15..0 and offset 0x74 returns pins 31..16 in bits [15:0], with [31:16] zero. The value read is pin_in as sampled two rising edges earlier, through a two-flop synchroniser.
- R7: Offset 0x78 reads the constant 0x01000C2B.
- R8: Reads of offsets that are unmapped or not word-aligned (for example 0x44, 0x50, 0x7C, 0x01) return zero. Writes to those offsets change no register and no pin.
- R9: When bus_we is low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| bus_rdata | output | 32 | Read word for bus_addr, combinational |
| pin_in | input | 32 | Pin levels from the pads, asynchronous |
| pin_out | output | 32 | Output-data register value |
| pin_oe | output | 32 | Direction register value, 1 = drive |

## Verification
A wrong enable decode in a half register shows up at pin_out or pin_oe on the edge right after the write. Either a bit with a clear enable changes, or the half that was not addressed moves. A slip in the address decode makes a readback return the wrong half or a non-zero word from an unmapped offset, which is visible on the next read. A synchroniser with the wrong number of stages shifts the first external-port read after a pin change by one cycle. So the bench reads the port both in the cycle the pins change and in the cycle after.

// File: rtl/gpio_bank_pkg.sv
// Package: shared sizes and offsets for the write-masked GPIO bank.
// Assumes two 16-bit halves per logical register, one logical register per 8 bytes.
package gpio_bank_pkg;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned HALF_W    = DATA_W / 2;
    localparam int unsigned NUM_PINS  = 32;
    localparam int unsigned NUM_CFG   = 8;
    localparam int unsigned CFG_IDX_W = $clog2(NUM_CFG);
    localparam int unsigned CFG_SPAN  = NUM_CFG * 8;
    localparam int unsigned SYNC_STAGES = 2;

    localparam int unsigned IDX_DOUT = 0;
    localparam int unsigned IDX_DIR  = 1;

    localparam logic [ADDR_W-1:0] EXT_OFF = 8'h70;
    localparam logic [ADDR_W-1:0] VER_OFF = 8'h78;
    localparam logic [DATA_W-1:0] VERSION_ID = 32'h0100_0C2B;

    typedef logic [NUM_CFG-1:0][NUM_PINS-1:0] cfg_bank_t;
endpackage

// File: rtl/gpio_masked_half.sv
// Module: one 16-bit register half with a bit-enable write.
// Assumes wdata[2W-1:W] are enables for wdata[W-1:0]; synchronous active-low reset to 0.
module gpio_masked_half #(
    parameter int unsigned W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2*W-1:0] wdata,
    output logic [W-1:0]   q
);
    logic [W-1:0] bit_en;
    logic [W-1:0] bit_val;

    // Split the incoming word into enables and data.
    always_comb begin
        bit_en  = wdata[2*W-1:W];
        bit_val = wdata[W-1:0];
    end

    // Update only the enabled bits; hold the rest.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= (q & ~bit_en) | (bit_val & bit_en);
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Module: multi-flop synchroniser for the pad input vector.
// Assumes each bit is independent; no bus coherency across bits is given.
module gpio_in_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage;

    // Shift the pad levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage <= '0;
        else
            stage <= {stage[STAGES-2:0], d};
    end

    // Last stage is the synchronised value.
    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_read_mux.sv
// Module: combinational read decode for the GPIO bank.
// Assumes word-aligned offsets; any other offset reads zero.
module gpio_read_mux
    import gpio_bank_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  cfg_bank_t           cfg,
    input  logic [NUM_PINS-1:0] ext,
    output logic [DATA_W-1:0]   rdata
);
    logic                 aligned;
    logic                 hi_half;
    logic [CFG_IDX_W-1:0] cfg_idx;

    // Derive the address fields used by every decode.
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        hi_half = addr[2];
        cfg_idx = addr[CFG_IDX_W+2:3];
    end

    // Select the word for the current offset; zero by default.
    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (addr < ADDR_W'(CFG_SPAN))
                rdata[HALF_W-1:0] = hi_half ? cfg[cfg_idx][NUM_PINS-1:HALF_W]
                                            : cfg[cfg_idx][HALF_W-1:0];
            else if (addr[ADDR_W-1:3] == EXT_OFF[ADDR_W-1:3])
                rdata[HALF_W-1:0] = hi_half ? ext[NUM_PINS-1:HALF_W]
                                            : ext[HALF_W-1:0];
            else if (addr == VER_OFF)
                rdata = VERSION_ID;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// Module: top of the write-masked GPIO bank.
// Assumes a single-cycle register bus: writes commit on the rising edge with
// bus_we high; reads are combinational from bus_addr.
module gpio_bank
    import gpio_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    localparam int unsigned HALVES = NUM_PINS / HALF_W;

    cfg_bank_t             cfg_q;
    logic [NUM_PINS-1:0]   ext_sync;
    logic                  wr_in_cfg;

    // Qualify a write as hitting the configuration window.
    always_comb begin
        wr_in_cfg = bus_we && (bus_addr[1:0] == 2'b00) && (bus_addr < ADDR_W'(CFG_SPAN));
    end

    for (genvar r = 0; r < NUM_CFG; r++) begin : g_reg
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            logic hit;
            // Decode the write strobe for this half.
            always_comb begin
                hit = wr_in_cfg
                      && (bus_addr[CFG_IDX_W+2:3] == CFG_IDX_W'(r))
                      && (bus_addr[2] == 1'(h));
            end

            gpio_masked_half #(.W(HALF_W)) u_half (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (hit),
                .wdata (bus_wdata),
                .q     (cfg_q[r][h*HALF_W +: HALF_W])
            );
        end
    end

    gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (ext_sync)
    );

    gpio_read_mux u_rmux (
        .addr  (bus_addr),
        .cfg   (cfg_q),
        .ext   (ext_sync),
        .rdata (bus_rdata)
    );

    assign pin_out = cfg_q[IDX_DOUT];
    assign pin_oe  = cfg_q[IDX_DIR];
endmodule

// File: rtl/gpio_bank_chk.sv
// Module: assertion checker for gpio_bank, attached by bind.
// Assumes reset is asserted from time zero.
module gpio_bank_chk
    import gpio_bank_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);
    logic [1:0] since_rst;

    // Count edges since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> (pin_out == '0 && pin_oe == '0));

    // R2
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h00) |=>
        pin_out[15:0] == (($past(pin_out[15:0]) & ~$past(bus_wdata[31:16]))
                        | ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

    // R3
    other_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h0C) |=> $stable(pin_oe[15:0]));

    // R9
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we || bus_addr[7:3] != 5'd0) |=> $stable(pin_out));

    // R6
    ext_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && bus_addr == 8'h70) |->
        bus_rdata == {16'h0000, $past(pin_in[15:0], 2)});

    // R6
    ext_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h74) |-> bus_rdata[31:16] == 16'h0000);

    // R7
    version_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == VER_OFF) |-> bus_rdata == VERSION_ID);

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h50 || bus_addr[1:0] != 2'b00) |-> bus_rdata == '0);
endmodule

bind gpio_bank gpio_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_bank_tb.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares them.
module gpio_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    gpio_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          kind;   // 0 read data, 1 pin_out, 2 pin_oe
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic        mon_valid = 1'b0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [31:0] model [8];

    // Monitor: after each rising edge, compare every queued item.
    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (mon_valid) begin
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? pin_out : pin_oe;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // Bus write, with the bench's own model of the masked update.
    task automatic wr(logic [7:0] a, logic [31:0] d, logic we = 1'b1);
        @(negedge clk);
        mon_valid = 1'b0;
        bus_addr = a; bus_we = we; bus_wdata = d;
        if (we && a[1:0] == 2'b00 && a < 8'h40) begin
            if (a[2])
                model[a[5:3]][31:16] = (model[a[5:3]][31:16] & ~d[31:16]) | (d[15:0] & d[31:16]);
            else
                model[a[5:3]][15:0]  = (model[a[5:3]][15:0]  & ~d[31:16]) | (d[15:0] & d[31:16]);
        end
    endtask

    // Read check with an explicit expected word; optionally change pins in the same cycle.
    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag,
                      bit chg = 1'b0, logic [31:0] pins = '0);
        @(negedge clk);
        push(0, exp, tag);
        bus_addr = a; bus_we = 1'b0; bus_wdata = '0;
        if (chg) pin_in = pins;
        mon_valid = 1'b1;
    endtask

    // Read check of a configuration half against the model.
    task automatic rd_cfg(logic [7:0] a, string tag);
        logic [31:0] w;
        w = model[a[5:3]];
        rd(a, {16'h0000, a[2] ? w[31:16] : w[15:0]}, tag);
    endtask

    // Check both pin vectors against the model.
    task automatic pins_chk(string tag);
        @(negedge clk);
        push(1, model[0], {tag, " pin_out"});
        push(2, model[1], {tag, " pin_oe"});
        bus_addr = 8'h40; bus_we = 1'b0; bus_wdata = '0;
        mon_valid = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        pins_chk("R1 reset");
        rd_cfg(8'h00, "R1 dout lo");
        rd_cfg(8'h0C, "R1 dir hi");
        rd_cfg(8'h10, "R1 ien lo");
        rd(8'h70, 32'h0, "R1 ext");

        // R4 / R3: full write of the low data half
        wr(8'h00, 32'hFFFF_A5A5);
        pins_chk("R4 dout lo");
        rd_cfg(8'h00, "R3 dout lo read");
        rd_cfg(8'h04, "R3 dout hi untouched");

        // R2: single-bit clear, single-bit set with extra unmasked data, empty mask
        wr(8'h00, 32'h0001_0000);
        pins_chk("R2 clear bit0");
        wr(8'h00, 32'h0002_FFFF);
        pins_chk("R2 set bit1 only");
        wr(8'h00, 32'h0000_FFFF);
        pins_chk("R2 empty mask");

        // R3: upper half of data
        wr(8'h04, 32'hFFFF_1234);
        pins_chk("R3 dout hi");
        rd_cfg(8'h00, "R3 lo kept");

        // R4: direction halves
        wr(8'h08, 32'h00F0_00FF);
        wr(8'h0C, 32'h8000_8000);
        pins_chk("R4 dir");
        rd_cfg(8'h08, "R4 dir lo read");

        // R5: configuration registers
        wr(8'h38, 32'hFFFF_BEEF);
        wr(8'h14, 32'h00FF_0055);
        wr(8'h28, 32'h0F0F_FFFF);
        rd_cfg(8'h38, "R5 debounce lo");
        rd_cfg(8'h3C, "R5 debounce hi");
        rd_cfg(8'h14, "R5 ien hi");
        rd_cfg(8'h28, "R5 pol lo");
        pins_chk("R5 pins untouched");

        // R9: strobe low
        wr(8'h00, 32'hFFFF_0000, 1'b0);
        wr(8'h08, 32'hFFFF_0000, 1'b0);
        pins_chk("R9 we low");

        // R8: unmapped and unaligned accesses
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_0000);
        wr(8'h7C, 32'hFFFF_FFFF);
        pins_chk("R8 writes ignored");
        rd_cfg(8'h38, "R8 cfg kept");
        rd(8'h50, 32'h0, "R8 read 0x50");
        rd(8'h44, 32'h0, "R8 read 0x44");
        rd(8'h7C, 32'h0, "R8 read 0x7C");
        rd(8'h01, 32'h0, "R8 read 0x01");

        // R7: identification word
        rd(8'h78, 32'h0100_0C2B, "R7 version");

        // R6: synchroniser latency and half split
        rd(8'h70, 32'h0000_0000, "R6 old value first", 1'b1, 32'hDEAD_BEEF);
        rd(8'h70, 32'h0000_BEEF, "R6 ext lo");
        rd(8'h74, 32'h0000_DEAD, "R6 ext hi");
        rd(8'h74, 32'h0000_DEAD, "R6 hold before update", 1'b1, 32'h1234_5678);
        rd(8'h74, 32'h0000_1234, "R6 ext hi new");
        rd(8'h70, 32'h0000_5678, "R6 ext lo new");

        @(negedge clk);
        mon_valid = 1'b0;
        bus_addr = 8'h40;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule